// File: doc/BRIEF.md
# Debug Register Scan Chain

This block is a debug register file that an external test-access-port controller reaches through a single data scan chain. Each frame is 38 bits wide. It holds a 32-bit data word, a 5-bit register address and a direction flag. The controller supplies one-cycle capture, shift and update strobes in the block's clock domain. A write frame commits its data word to the addressed register when the update strobe arrives. A read frame only sets which register is selected. The next capture loads that register's contents into the data field of the shift register, so a read returns its data one scan later.

The register file contains a debug control register, a debug status register that reflects core state, a vector catch register, and two watchpoint units. Each watchpoint unit has value and mask registers for address, data and control. There is also a communications channel between the debugger and the core. It consists of a control register that carries two handshake flags and a version number, plus a data mailbox. The mailbox has a word flowing toward the core and a word flowing from the core. The core side has its own read and write strobes.

Top module: `dbgscan_top`

## Requirements
- R1: Frame layout: bit 37 is the direction flag (1 = write, 0 = read), bits 36:32 are the register address, and bits 31:0 are data. On capture, bits 31:0 load the selected register and bits 37:32 load zero. While shifting, `tdo` presents bit 0 and `tdi` enters bit 37 on each shift cycle.
- R2: A write frame changes a register only on the update strobe. Nothing changes during capture or shift. A frame with flag 0 writes nothing.
- R3: A read frame sets the selected address at update, and the following capture returns that register. A write frame leaves the selection unchanged.
- R4: After reset, every register and both handshake flags are zero, and the selected address is comms control (0x4).
- R5: Debug control (0x0) is 6 bits wide and is writable. Bit 4 (monitor enable) reads back the last value written. Debug status (0x1) returns the 5-bit `dbgStatus` input. Upper bits read as zero, and writes to 0x1 are ignored.
- R6: Reading comms control (0x4) returns bit 0 = R, bit 1 = W, bits 31:28 = VERSION, and zero in all other bits. Writes to 0x4 have no effect.
- R7: A debugger write to comms data (0x5) loads `toCoreData` and sets R. A `coreRd` pulse clears R.
- R8: A `coreWr` pulse loads the from-core word and sets W. Every capture taken while 0x5 is selected returns that word and clears W, including a repeated capture caused by leaving 0x5 selected.
- R9: Vector catch (0x2) holds 8 bits. Watchpoint unit u, register k (k = 0..5 in the order address value, address mask, data value, data mask, control value, control mask) sits at address 8 + 8u + k. It reads back at full width and appears on `wpRegs[(6u+k)*32 +: 32]`.
- R10: Addresses outside the map read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the scan strobes and the core side |
| rstN | input | 1 | Active-low synchronous reset |
| captureDr | input | 1 | Capture strobe from the TAP controller |
| shiftDr | input | 1 | Shift strobe, one bit per cycle |
| updateDr | input | 1 | Update strobe from the TAP controller |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output (bit 0 of the shift register) |
| dbgStatus | input | 5 | Core status bits that debug status reads |
| coreRd | input | 1 | Core takes the to-core mailbox word |
| coreWr | input | 1 | Core deposits a word for the debugger |
| coreWrData | input | 32 | Word written by the core |
| toCoreData | output | 32 | Mailbox word written by the debugger |
| commsR | output | 1 | R handshake flag |
| commsW | output | 1 | W handshake flag |
| dbgCtrl | output | 6 | Debug control register |
| vecCatch | output | 8 | Vector catch register |
| wpRegs | output | 384 | All watchpoint registers, packed |

## Verification
The bench sweeps all 32 addresses with two data patterns and checks each readback against a model. A decoder that aliases or drops an address, or that fails to mask a narrow register, shows up as wrong data at some address. The one-scan read latency is tested by checking that a write frame does not move the selection, so a decoder that lets writes re-select would return the wrong register. The comms tests cover flag set and clear from both sides. They also cover the repeated capture of comms data: a design that consumed the mailbox only on an explicit read would leave W set. A mid-scan check confirms that debug control does not change before update, which catches a design that commits writes on shift.

// File: rtl/dbgscan_pkg.sv
package dbgscan_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 5;
  localparam int FRAME_W = DATA_W + ADDR_W + 1;
  localparam int WP_REGS = 6;

  localparam logic [ADDR_W-1:0] ADR_DBGCTRL = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_DBGSTAT = 5'h01;
  localparam logic [ADDR_W-1:0] ADR_VCATCH  = 5'h02;
  localparam logic [ADDR_W-1:0] ADR_COMCTRL = 5'h04;
  localparam logic [ADDR_W-1:0] ADR_COMDATA = 5'h05;
  localparam int                WP_BASE     = 8;
  localparam int                WP_STRIDE   = 8;

  typedef struct packed {
    logic              capture;
    logic [ADDR_W-1:0] rdAddr;
    logic              write;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
  } scanStrobe_t;

  function automatic logic [ADDR_W-1:0] wpAddrOf(input int idx);
    return ADDR_W'(WP_BASE + (idx / WP_REGS) * WP_STRIDE + (idx % WP_REGS));
  endfunction
endpackage

// File: rtl/dbgscan_ctrl.sv
module dbgscan_ctrl
  import dbgscan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              captureDr,
  input  logic              shiftDr,
  input  logic              updateDr,
  input  logic              tdi,
  input  logic [DATA_W-1:0] rdData,
  output logic              tdo,
  output scanStrobe_t       strb
);
  localparam int HI_W = FRAME_W - DATA_W;

  logic [FRAME_W-1:0] shiftReg;
  logic [ADDR_W-1:0]  selAddr;
  logic               frameWr;
  logic [ADDR_W-1:0]  frameAddr;
  logic               doUpdate;

  assign frameWr   = shiftReg[FRAME_W-1];
  assign frameAddr = shiftReg[DATA_W +: ADDR_W];
  assign doUpdate  = updateDr && !captureDr && !shiftDr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      selAddr  <= ADR_COMCTRL;
    end else if (captureDr) begin
      shiftReg <= {{HI_W{1'b0}}, rdData};
    end else if (shiftDr) begin
      shiftReg <= {tdi, shiftReg[FRAME_W-1:1]};
    end else if (doUpdate && !frameWr) begin
      selAddr <= frameAddr;
    end
  end

  always_comb begin
    strb         = '0;
    strb.capture = captureDr;
    strb.rdAddr  = selAddr;
    strb.write   = doUpdate && frameWr;
    strb.wrAddr  = frameAddr;
    strb.wrData  = shiftReg[DATA_W-1:0];
  end

  assign tdo = shiftReg[0];

  assert_capture_clears_hi_R1: assert property (@(posedge clk) disable iff (!rstN)
    captureDr |=> (shiftReg[FRAME_W-1:DATA_W] == '0));

  assert_shift_enters_msb_R1: assert property (@(posedge clk) disable iff (!rstN)
    (shiftDr && !captureDr) |=> (shiftReg[FRAME_W-1] == $past(tdi)));

  assert_write_keeps_sel_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.write |=> $stable(selAddr));
endmodule

// File: rtl/dbgscan_regs.sv
module dbgscan_regs
  import dbgscan_pkg::*;
#(
  parameter int         NUM_WP  = 2,
  parameter int         CTRL_W  = 6,
  parameter int         STAT_W  = 5,
  parameter int         VC_W    = 8,
  parameter logic [3:0] VERSION = 4'h5
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  scanStrobe_t                     strb,
  input  logic [STAT_W-1:0]               dbgStatus,
  input  logic                            coreRd,
  input  logic                            coreWr,
  input  logic [DATA_W-1:0]               coreWrData,
  output logic [DATA_W-1:0]               rdData,
  output logic [DATA_W-1:0]               toCoreData,
  output logic                            commsR,
  output logic                            commsW,
  output logic [CTRL_W-1:0]               dbgCtrl,
  output logic [VC_W-1:0]                 vecCatch,
  output logic [NUM_WP*WP_REGS*DATA_W-1:0] wpRegs
);
  localparam int WP_N = NUM_WP * WP_REGS;

  logic [CTRL_W-1:0]             ctrlQ;
  logic [VC_W-1:0]               vcQ;
  logic [WP_N-1:0][DATA_W-1:0]   wpQ;
  logic [WP_N-1:0]               wpHit;
  logic [DATA_W-1:0]             toCoreQ;
  logic [DATA_W-1:0]             fromCoreQ;
  logic                          rFlag;
  logic                          wFlag;
  logic                          jtagWrMail;
  logic                          jtagRdMail;
  logic [DATA_W-1:0]             wpRead;

  assign jtagWrMail = strb.write && (strb.wrAddr == ADR_COMDATA);
  assign jtagRdMail = strb.capture && (strb.rdAddr == ADR_COMDATA);

  for (genvar gi = 0; gi < WP_N; gi++) begin : g_wpHit
    assign wpHit[gi] = strb.write && (strb.wrAddr == wpAddrOf(gi));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      vcQ   <= '0;
      wpQ   <= '0;
    end else begin
      if (strb.write && strb.wrAddr == ADR_DBGCTRL) ctrlQ <= strb.wrData[CTRL_W-1:0];
      if (strb.write && strb.wrAddr == ADR_VCATCH)  vcQ   <= strb.wrData[VC_W-1:0];
      for (int i = 0; i < WP_N; i++) begin
        if (wpHit[i]) wpQ[i] <= strb.wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toCoreQ   <= '0;
      fromCoreQ <= '0;
      rFlag     <= 1'b0;
      wFlag     <= 1'b0;
    end else begin
      if (jtagWrMail) toCoreQ <= strb.wrData;
      if (coreWr)     fromCoreQ <= coreWrData;
      if (jtagWrMail)  rFlag <= 1'b1;
      else if (coreRd) rFlag <= 1'b0;
      if (coreWr)          wFlag <= 1'b1;
      else if (jtagRdMail) wFlag <= 1'b0;
    end
  end

  always_comb begin
    wpRead = '0;
    for (int i = 0; i < WP_N; i++) begin
      if (strb.rdAddr == wpAddrOf(i)) wpRead = wpQ[i];
    end
  end

  always_comb begin
    case (strb.rdAddr)
      ADR_DBGCTRL: rdData = {{(DATA_W-CTRL_W){1'b0}}, ctrlQ};
      ADR_DBGSTAT: rdData = {{(DATA_W-STAT_W){1'b0}}, dbgStatus};
      ADR_VCATCH:  rdData = {{(DATA_W-VC_W){1'b0}}, vcQ};
      ADR_COMCTRL: rdData = {VERSION, {(DATA_W-6){1'b0}}, wFlag, rFlag};
      ADR_COMDATA: rdData = fromCoreQ;
      default:     rdData = wpRead;
    endcase
  end

  assign toCoreData = toCoreQ;
  assign commsR     = rFlag;
  assign commsW     = wFlag;
  assign dbgCtrl    = ctrlQ;
  assign vecCatch   = vcQ;
  assign wpRegs     = wpQ;

  assert_jtag_write_sets_r_R7: assert property (@(posedge clk) disable iff (!rstN)
    jtagWrMail |=> commsR);

  assert_core_read_clears_r_R7: assert property (@(posedge clk) disable iff (!rstN)
    (coreRd && !jtagWrMail) |=> !commsR);

  assert_read_consumes_w_R8: assert property (@(posedge clk) disable iff (!rstN)
    (jtagRdMail && !coreWr) |=> !commsW);

  assert_core_write_sets_w_R8: assert property (@(posedge clk) disable iff (!rstN)
    coreWr |=> commsW);

  assert_ctrl_only_on_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.write && strb.wrAddr == ADR_DBGCTRL) |=> $stable(dbgCtrl));
endmodule

// File: rtl/dbgscan_top.sv
module dbgscan_top
  import dbgscan_pkg::*;
#(
  parameter int         NUM_WP  = 2,
  parameter int         CTRL_W  = 6,
  parameter int         STAT_W  = 5,
  parameter int         VC_W    = 8,
  parameter logic [3:0] VERSION = 4'h5
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             captureDr,
  input  logic                             shiftDr,
  input  logic                             updateDr,
  input  logic                             tdi,
  output logic                             tdo,
  input  logic [STAT_W-1:0]                dbgStatus,
  input  logic                             coreRd,
  input  logic                             coreWr,
  input  logic [31:0]                      coreWrData,
  output logic [31:0]                      toCoreData,
  output logic                             commsR,
  output logic                             commsW,
  output logic [CTRL_W-1:0]                dbgCtrl,
  output logic [VC_W-1:0]                  vecCatch,
  output logic [NUM_WP*WP_REGS*32-1:0]     wpRegs
);
  scanStrobe_t       strb;
  logic [DATA_W-1:0] rdData;

  dbgscan_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .captureDr (captureDr),
    .shiftDr   (shiftDr),
    .updateDr  (updateDr),
    .tdi       (tdi),
    .rdData    (rdData),
    .tdo       (tdo),
    .strb      (strb)
  );

  dbgscan_regs #(
    .NUM_WP  (NUM_WP),
    .CTRL_W  (CTRL_W),
    .STAT_W  (STAT_W),
    .VC_W    (VC_W),
    .VERSION (VERSION)
  ) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .dbgStatus  (dbgStatus),
    .coreRd     (coreRd),
    .coreWr     (coreWr),
    .coreWrData (coreWrData),
    .rdData     (rdData),
    .toCoreData (toCoreData),
    .commsR     (commsR),
    .commsW     (commsW),
    .dbgCtrl    (dbgCtrl),
    .vecCatch   (vecCatch),
    .wpRegs     (wpRegs)
  );
endmodule

// File: tb/dbgscan_top_bench.sv
module dbgscan_top_bench;
  localparam logic [3:0] VER = 4'h5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0, tdi = 1'b0;
  logic tdo;
  logic [4:0] dbgStatus = 5'h15;
  logic coreRd = 1'b0, coreWr = 1'b0;
  logic [31:0] coreWrData = '0;
  logic [31:0] toCoreData;
  logic commsR, commsW;
  logic [5:0] dbgCtrl;
  logic [7:0] vecCatch;
  logic [383:0] wpRegs;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  dbgscan_top #(.VERSION(VER)) u_dbgscan_top (
    .clk(clk), .rstN(rstN), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .tdi(tdi), .tdo(tdo), .dbgStatus(dbgStatus),
    .coreRd(coreRd), .coreWr(coreWr), .coreWrData(coreWrData),
    .toCoreData(toCoreData), .commsR(commsR), .commsW(commsW),
    .dbgCtrl(dbgCtrl), .vecCatch(vecCatch), .wpRegs(wpRegs)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic logic [37:0] mk(input logic wr, input logic [4:0] a, input logic [31:0] d);
    return {wr, a, d};
  endfunction

  task automatic shiftFrame(input logic [37:0] outF, output logic [37:0] inF);
    @(negedge clk) captureDr = 1'b1;
    @(negedge clk) captureDr = 1'b0;
    for (int i = 0; i < 38; i++) begin
      inF[i] = tdo;
      tdi = outF[i];
      shiftDr = 1'b1;
      @(negedge clk);
    end
    shiftDr = 1'b0;
  endtask

  task automatic doUpdate();
    updateDr = 1'b1;
    @(negedge clk) updateDr = 1'b0;
  endtask

  task automatic scan(input logic [37:0] outF, output logic [37:0] inF);
    shiftFrame(outF, inF);
    doUpdate();
  endtask

  task automatic writeReg(input logic [4:0] a, input logic [31:0] d);
    logic [37:0] dummy;
    scan(mk(1'b1, a, d), dummy);
  endtask

  task automatic readReg(input logic [4:0] a, output logic [31:0] d);
    logic [37:0] f;
    scan(mk(1'b0, a, 32'h0), f);
    scan(mk(1'b0, 5'h4, 32'h0), f);
    d = f[31:0];
  endtask

  function automatic logic [31:0] pat(input int a, input logic inv);
    logic [31:0] p;
    p = 32'h9E3779B9 * (a + 1);
    return inv ? ~p : p;
  endfunction

  function automatic bit isWp(input int a);
    return (a >= 8 && a <= 13) || (a >= 16 && a <= 21);
  endfunction

  function automatic int wpIdx(input int a);
    return ((a >> 3) - 1) * 6 + (a & 7);
  endfunction

  function automatic logic [31:0] expRead(input int a, input logic inv);
    if (a == 0) return pat(a, inv) & 32'h3F;
    if (a == 1) return {27'h0, dbgStatus};
    if (a == 2) return pat(a, inv) & 32'hFF;
    if (a == 4) return {VER, 28'h0};
    if (a == 5) return 32'h0;
    if (isWp(a)) return pat(a, inv);
    return 32'h0;
  endfunction

  initial begin
    logic [37:0] f;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R4 reset state at the ports
    check("R4 dbgCtrl reset", dbgCtrl, 0);
    check("R4 vecCatch reset", vecCatch, 0);
    check("R4 wpRegs reset", (wpRegs == '0), 1);
    check("R4 commsR reset", commsR, 0);
    check("R4 commsW reset", commsW, 0);
    // R4 default selection is comms control; R1 upper captured bits are zero
    scan(mk(1'b0, 5'h4, 32'h0), f);
    check("R4 default selection reads comms ctrl", f[31:0], {VER, 28'h0});
    check("R1 captured addr/flag zero", f[37:32], 0);

    // R9 R10 R5 sweep over all addresses with two patterns
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 32; a++) begin
        if (a != 4 && a != 5) writeReg(5'(a), pat(a, p[0]));
      end
      for (int a = 0; a < 32; a++) begin
        readReg(5'(a), d);
        check($sformatf("R9/R10/R5 readback addr 0x%0h", a), d, expRead(a, p[0]));
        if (isWp(a))
          check($sformatf("R9 wpRegs slot addr 0x%0h", a), wpRegs[wpIdx(a)*32 +: 32], pat(a, p[0]));
      end
      check("R9 vecCatch port", vecCatch, pat(2, p[0]) & 32'hFF);
      check("R5 dbgCtrl port", dbgCtrl, pat(0, p[0]) & 32'h3F);
    end

    // R2 no commit during shift; R5 monitor enable bit 4
    shiftFrame(mk(1'b1, 5'h0, 32'h10), f);
    check("R2 dbgCtrl unchanged before update", dbgCtrl, pat(0, 1'b1) & 32'h3F);
    doUpdate();
    check("R2 dbgCtrl after update", dbgCtrl, 6'h10);
    readReg(5'h0, d);
    check("R5 monitor enable reads back 1", d, 32'h10);
    writeReg(5'h0, 32'h0);
    readReg(5'h0, d);
    check("R5 monitor enable reads back 0", d, 32'h0);
    // R2 read frame writes nothing
    scan(mk(1'b0, 5'h0, 32'h3F), f);
    check("R2 read frame leaves dbgCtrl", dbgCtrl, 6'h0);

    // R3 write frame does not move the selection
    writeReg(5'h2, 32'h5A);
    scan(mk(1'b0, 5'h2, 32'h0), f);
    scan(mk(1'b1, 5'h0, 32'h0), f);
    check("R3 capture after select", f[31:0], 32'h5A);
    scan(mk(1'b0, 5'h4, 32'h0), f);
    check("R3 write frame kept selection", f[31:0], 32'h5A);

    // R7 debugger to core
    writeReg(5'h5, 32'hCAFE_F00D);
    check("R7 toCoreData", toCoreData, 32'hCAFE_F00D);
    check("R7 commsR set", commsR, 1);
    readReg(5'h4, d);
    check("R6/R7 comms ctrl shows R", d, {VER, 26'h0, 2'b01});
    @(negedge clk) coreRd = 1'b1;
    @(negedge clk) coreRd = 1'b0;
    check("R7 coreRd clears R", commsR, 0);

    // R8 core to debugger
    @(negedge clk) begin coreWr = 1'b1; coreWrData = 32'h1234_5678; end
    @(negedge clk) coreWr = 1'b0;
    check("R8 commsW set", commsW, 1);
    readReg(5'h4, d);
    check("R6/R8 comms ctrl shows W", d, {VER, 26'h0, 2'b10});
    readReg(5'h5, d);
    check("R8 mailbox word", d, 32'h1234_5678);
    check("R8 read clears W", commsW, 0);

    // R8 repeated capture with comms data left selected
    @(negedge clk) begin coreWr = 1'b1; coreWrData = 32'hAAAA_0001; end
    @(negedge clk) coreWr = 1'b0;
    scan(mk(1'b0, 5'h5, 32'h0), f);
    scan(mk(1'b0, 5'h5, 32'h0), f);
    check("R8 first burst word", f[31:0], 32'hAAAA_0001);
    @(negedge clk) begin coreWr = 1'b1; coreWrData = 32'hBBBB_0002; end
    @(negedge clk) coreWr = 1'b0;
    check("R8 W set again", commsW, 1);
    scan(mk(1'b0, 5'h4, 32'h0), f);
    check("R8 extra capture returns word", f[31:0], 32'hBBBB_0002);
    check("R8 extra capture consumed W", commsW, 0);
    scan(mk(1'b0, 5'h4, 32'h0), f);
    check("R8 ctrl after burst", f[31:0], {VER, 28'h0});

    // R6 writes to comms control ignored
    writeReg(5'h4, 32'hFFFF_FFFF);
    readReg(5'h4, d);
    check("R6 comms ctrl write ignored", d, {VER, 28'h0});
    check("R6 flags unchanged", {commsW, commsR}, 2'b00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule